// File: doc/BRIEF.md
# Binary/Decimal Complement Unit

This block is a purely combinational complement stage that sits ahead of an adder which handles both binary and packed-BCD sums. It takes a data word and two controls, `invert` and `decimal`. With `invert` low the word passes straight through. With `invert` high and `decimal` low, every bit is flipped, which gives the ones' complement needed for binary subtraction by addition. With both controls high, every 4-bit digit is replaced by its nine's complement, so the adder can perform decimal subtraction as an addition.

The word is split into independent 4-bit digit slices. Each slice is itself split into two bit pairs. The low output pair reads only the two low input bits of its digit. The high output pair reads only the three high input bits. Codes that are not valid BCD digits (10 to 15) still give defined results: nine minus the code, taken modulo sixteen.

Top module: `cmpl_unit`

## Requirements
- R1: When `invert` is 0, `dout` equals `din` for either value of `decimal`.
- R2: When `invert` is 1 and `decimal` is 0, `dout` equals the bitwise inverse of `din`, so each digit x becomes 15 - x.
- R3: When `invert` and `decimal` are both 1, each digit (bits 4k+3..4k) holding a value x from 0 to 9 becomes 9 - x.
- R4: When `invert` and `decimal` are both 1, digit codes 10 to 15 map to (9 - x) mod 16: 10 gives 15, 11 gives 14, 12 gives 13, 13 gives 12, 14 gives 11, and 15 gives 10.
- R5: Each output digit depends only on the input digit at the same position and on the two controls. Contents of other digits have no effect on it.
- R6: Output bits 1..0 of each digit depend only on input bits 1..0 of that digit and the controls. Changing input bits 3..2 leaves them unchanged.
- R7: Output bits 3..2 of each digit depend only on input bits 3..1 of that digit and the controls. Changing input bit 0 leaves them unchanged.
- R8: The block has no storage. `dout` follows any change of `din`, `invert` or `decimal` within the same time step, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | WIDTH (32) | Operand word, made of WIDTH/4 digit slices |
| invert | input | 1 | 1 selects a complement; 0 passes the word through |
| decimal | input | 1 | With `invert` high, 1 selects nine's complement per digit |
| dout | output | WIDTH (32) | Complemented or passed-through word |

## Verification
The hardest situation to reach from the ports is proving that digits are isolated from one another and that each bit pair ignores the input bits it should not read. A broad sweep with matching inputs can hide a wrong cross-connection, because the wrong source may hold the same value. To expose this, the bench places each of the 16 codes in each digit position in turn, surrounded by random neighbours. It also flips only bits 3..2, or only bit 0, of every digit and compares the untouched output pair before and after the change. The decimal-mode codes 10 to 15 are swept one by one, because their results break the pattern of the valid BCD digits.

// File: rtl/cmpl_pkg.sv
package cmpl_pkg;

  localparam int unsigned DIGIT_W = 4;

  typedef enum logic [1:0] {
    MODE_PASS = 2'b00,
    MODE_BIN  = 2'b01,
    MODE_DEC  = 2'b10
  } cmpl_mode_e;

  function automatic cmpl_mode_e decode_mode(input logic inv, input logic dec);
    cmpl_mode_e m;
    if (!inv)     m = MODE_PASS;
    else if (dec) m = MODE_DEC;
    else          m = MODE_BIN;
    return m;
  endfunction

endpackage

// File: rtl/cmpl_lo_pair.sv
module cmpl_lo_pair
  import cmpl_pkg::*;
(
  input  logic [1:0] lo_in,
  input  cmpl_mode_e mode,
  output logic [1:0] lo_out
);

  // (9 - x) mod 4 == (1 - x) mod 4: bit1 keeps, bit0 flips
  always_comb begin
    unique case (mode)
      MODE_PASS: lo_out = lo_in;
      MODE_BIN:  lo_out = ~lo_in;
      MODE_DEC:  lo_out = {lo_in[1], ~lo_in[0]};
      default:   lo_out = lo_in;
    endcase
  end

  always_comb begin
    if (!$isunknown({mode, lo_in}) && mode == MODE_DEC) begin
      // R3
      lo_dec_sum_chk: assert (2'(lo_out + lo_in) == 2'd1)
        else $error("low pair decimal sum not 1 mod 4");
    end
  end

endmodule

// File: rtl/cmpl_hi_pair.sv
module cmpl_hi_pair
  import cmpl_pkg::*;
(
  input  logic [2:0] hi_in,
  input  cmpl_mode_e mode,
  output logic [1:0] hi_out
);

  logic [2:0] dec_diff;

  // Upper pair of (9 - x) equals bits 2..1 of (4 - x[3:1]) in 3-bit arithmetic
  always_comb dec_diff = 3'd4 - hi_in;

  always_comb begin
    unique case (mode)
      MODE_PASS: hi_out = hi_in[2:1];
      MODE_BIN:  hi_out = ~hi_in[2:1];
      MODE_DEC:  hi_out = dec_diff[2:1];
      default:   hi_out = hi_in[2:1];
    endcase
  end

  always_comb begin
    if (!$isunknown({mode, hi_in}) && mode == MODE_BIN) begin
      // R2
      hi_bin_flip_chk: assert ((hi_out ^ hi_in[2:1]) == 2'b11)
        else $error("high pair binary output not inverted");
    end
  end

endmodule

// File: rtl/cmpl_digit.sv
module cmpl_digit
  import cmpl_pkg::*;
(
  input  logic [DIGIT_W-1:0] digit_in,
  input  cmpl_mode_e         mode,
  output logic [DIGIT_W-1:0] digit_out
);

  logic [1:0] lo_res;
  logic [1:0] hi_res;

  cmpl_lo_pair u_lo (
    .lo_in  (digit_in[1:0]),
    .mode   (mode),
    .lo_out (lo_res)
  );

  cmpl_hi_pair u_hi (
    .hi_in  (digit_in[3:1]),
    .mode   (mode),
    .hi_out (hi_res)
  );

  always_comb digit_out = {hi_res, lo_res};

  always_comb begin
    if (!$isunknown({mode, digit_in}) && mode == MODE_DEC) begin
      // R3 R4
      digit_nine_chk: assert (4'(digit_out + digit_in) == 4'd9)
        else $error("digit decimal sum not 9 mod 16");
    end
  end

endmodule

// File: rtl/cmpl_unit.sv
module cmpl_unit
  import cmpl_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] din,
  input  logic             invert,
  input  logic             decimal,
  output logic [WIDTH-1:0] dout
);

  localparam int unsigned NDIGITS = WIDTH / DIGIT_W;

  cmpl_mode_e mode;

  always_comb mode = decode_mode(invert, decimal);

  for (genvar g = 0; g < NDIGITS; g++) begin : g_digit
    cmpl_digit u_digit (
      .digit_in  (din[g*DIGIT_W +: DIGIT_W]),
      .mode      (mode),
      .digit_out (dout[g*DIGIT_W +: DIGIT_W])
    );
  end

  always_comb begin
    if (!$isunknown({invert, decimal, din})) begin
      // R1
      pass_through_chk: assert (invert || dout == din)
        else $error("output differs from input with invert low");
      // R2
      bin_word_chk: assert (!(invert && !decimal) || (dout ^ din) == {WIDTH{1'b1}})
        else $error("binary complement incomplete");
    end
  end

endmodule

// File: tb/cmpl_unit_tb.sv
module cmpl_unit_tb;

  localparam int unsigned WIDTH = 32;
  localparam int unsigned ND    = WIDTH / 4;
  localparam int unsigned WATCHDOG = 100000;

  logic             clk;
  logic             rst_n;
  logic [WIDTH-1:0] din;
  logic             invert;
  logic             decimal;
  logic [WIDTH-1:0] dout;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done   = 0;

  cmpl_unit #(.WIDTH(WIDTH)) u_dut (
    .din     (din),
    .invert  (invert),
    .decimal (decimal),
    .dout    (dout)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [WIDTH-1:0] expect_word(logic [WIDTH-1:0] w, logic inv, logic dec);
    logic [WIDTH-1:0] r;
    for (int k = 0; k < ND; k++) begin
      logic [3:0] x;
      x = w[k*4 +: 4];
      if (!inv)     r[k*4 +: 4] = x;
      else if (dec) r[k*4 +: 4] = 4'd9 - x;
      else          r[k*4 +: 4] = 4'd15 - x;
    end
    return r;
  endfunction

  task automatic check(string req, logic [WIDTH-1:0] act, logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (din=%h inv=%0b dec=%0b)",
               req, act, exp, din, invert, decimal);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic apply(logic [WIDTH-1:0] w, logic inv, logic dec);
    @(posedge clk);
    #1;
    din = w; invert = inv; decimal = dec;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    logic [WIDTH-1:0] ref_out;
    logic [WIDTH-1:0] mask;
    rst_n = 1'b0; din = '0; invert = 1'b0; decimal = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state", dout, '0);

    // Every code replicated across all digits, all control combinations
    for (int c = 0; c < 4; c++) begin
      for (int v = 0; v < 16; v++) begin
        logic inv, dec;
        inv = c[1]; dec = c[0];
        apply({ND{v[3:0]}}, inv, dec);
        if (!inv)       check("R1", dout, expect_word(din, inv, dec));
        else if (!dec)  check("R2", dout, expect_word(din, inv, dec));
        else if (v < 10) check("R3", dout, expect_word(din, inv, dec));
        else            check("R4", dout, expect_word(din, inv, dec));
      end
    end

    // Explicit table for non-BCD codes
    for (int v = 10; v < 16; v++) begin
      logic [3:0] e;
      e = 4'(25 - v);
      apply(WIDTH'(v), 1'b1, 1'b1);
      check("R4 code table", {28'd0, dout[3:0]}, {28'd0, e});
    end

    // Each code in each position with random neighbours
    for (int c = 0; c < 4; c++) begin
      for (int p = 0; p < ND; p++) begin
        for (int v = 0; v < 16; v++) begin
          logic [WIDTH-1:0] w;
          w = $urandom();
          w[p*4 +: 4] = v[3:0];
          apply(w, c[1], c[0]);
          check("R5", dout, expect_word(w, c[1], c[0]));
        end
      end
    end

    // Low pair ignores bits 3..2, high pair ignores bit 0
    for (int c = 0; c < 4; c++) begin
      for (int n = 0; n < 40; n++) begin
        logic [WIDTH-1:0] w, base;
        w = $urandom();
        apply(w, c[1], c[0]);
        base = dout;
        mask = {ND{4'b0011}};
        apply(w ^ {ND{4'b1100}}, c[1], c[0]);
        check("R6", dout & mask, base & mask);
        mask = {ND{4'b1100}};
        apply(w ^ {ND{4'b0001}}, c[1], c[0]);
        check("R7", dout & mask, base & mask);
      end
    end

    // Random words in every mode
    for (int n = 0; n < 400; n++) begin
      logic [WIDTH-1:0] w;
      logic [1:0] c;
      w = $urandom(); c = 2'($urandom());
      apply(w, c[1], c[0]);
      check("R3 R2 R1 random", dout, expect_word(w, c[1], c[0]));
    end

    // No clock edge between input change and output observation
    @(negedge clk);
    din = 32'h0123_4567; invert = 1'b1; decimal = 1'b1;
    #1;
    check("R8 dec", dout, 32'h9876_5432);
    decimal = 1'b0;
    #1;
    check("R8 bin", dout, 32'hFEDC_BA98);
    invert = 1'b0;
    #1;
    check("R8 pass", dout, 32'h0123_4567);

    finish_run();
  end

endmodule